// File: doc/BRIEF.md
# Built-in Test Step Sequencer

This block paces a built-in self-test run. A programmable tick divider turns the system clock into a slow, narrow base pulse train. A toggle stage halves that train into a square-wave step clock. A strobe is formed wherever a base pulse overlaps the high phase of the step clock. A 4-bit step counter moves forward once per step-clock period, and its value is decoded into sixteen active-low, one-hot step-select lines that enable one test at a time.

An asynchronous active-low reset parks the sequence on step 0, which is the power check, so that step is already selected when reset is released. The release passes through a two-stage synchronizer. A jump request loads a fixed step number instead of incrementing. Either of two inhibit lines blanks every step-select output. All logic runs on a single clock. The base pulse width and the base period are parameters counted in clock cycles, so short time scales can be used for test.

Top module: `bist_step_sequencer`

## Requirements
- R1: While `rst_n` is low, `step_count` is 0, `step_clk` and `strobe` are low, and `step_sel_n` is 16'hFFFE (bit 0 low), unless inhibited.
- R2: A rising `rst_n` takes effect through two synchronizer edges. The logic first advances on the third rising clock edge after the release.
- R3: Counting from the first advancing edge as edge 1, the base pulse is high after edges k where (k-1) mod PERIOD_CYC < PULSE_CYC. `step_clk` toggles on each edge where the base pulse ends, that is k = PULSE_CYC+1 + n*PERIOD_CYC.
- R4: `strobe` is high exactly while the base pulse and `step_clk` are both high. Each strobe is PULSE_CYC cycles wide and directly precedes a falling `step_clk`.
- R5: `step_count` changes only on the edge where `step_clk` falls. With no jump request on that edge, it increments by one.
- R6: The count wraps from 15 to 0.
- R7: If `jump_req` is high on the edge where `step_clk` falls, the count loads JUMP_STEP (default 6) instead of incrementing. A `jump_req` on any other edge leaves the count unchanged.
- R8: With both inhibits low, `step_sel_n[i]` is 0 exactly when `step_count == i`, and every other bit is 1.
- R9: If `dec_inh_a` or `dec_inh_b` is high, `step_sel_n` is 16'hFFFF at once. The step counter keeps running underneath.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| jump_req | input | 1 | Load JUMP_STEP on the next step advance |
| dec_inh_a | input | 1 | Decoder inhibit, active high |
| dec_inh_b | input | 1 | Decoder inhibit, active high |
| step_sel_n | output | 16 | One-hot active-low step selects |
| strobe | output | 1 | Test strobe |
| step_clk | output | 1 | Square-wave step clock |
| step_count | output | 4 | Current step number |

## Verification
The bench drives a full pass through all sixteen steps, so the 15-to-0 wrap is exercised. A counter that saturated, or that wrapped to JUMP_STEP, would diverge at that step. Jump requests are placed both on step-advance edges and off them. A design that sampled the request on the wrong edge, or let an increment win over the load, would show a wrong count. Inhibits are raised in the middle of steps, which catches a decoder that waits for a clock before blanking or that freezes the counter. A reset is applied mid-run to expose a missing synchronizer delay and to confirm that the first step is not cut short.

// File: rtl/bist_seq_pkg.sv
package bist_seq_pkg;
  localparam int STEP_W = 4;
  localparam int STEP_N = 1 << STEP_W;
  typedef logic [STEP_W-1:0] step_t;
  localparam step_t JUMP_STEP_DEF = step_t'(6);
endpackage

// File: rtl/bist_rst_sync.sv
module bist_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bist_pulse_gen.sv
module bist_pulse_gen #(
  parameter int PERIOD_CYC = 1_000_000,
  parameter int PULSE_CYC  = 50_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic base_o,
  output logic fall_o
);
  localparam int PH_W = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [PH_W-1:0] PH_LAST  = PH_W'(PERIOD_CYC - 1);
  localparam logic [PH_W-1:0] PH_PULSE = PH_W'(PULSE_CYC);

  logic [PH_W-1:0] phase_q, phase_d;
  logic            base_q, base_d;

  // next state: free-running phase, pulse high for the first PULSE_CYC phases
  always_comb begin
    phase_d = (phase_q == PH_LAST) ? '0 : phase_q + PH_W'(1);
    base_d  = (phase_q < PH_PULSE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      base_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      base_q  <= base_d;
    end
  end

  assign base_o = base_q;
  assign fall_o = base_q & ~base_d;
endmodule

// File: rtl/bist_step_clk.sv
module bist_step_clk (
  input  logic clk,
  input  logic rst_n,
  input  logic base_i,
  input  logic fall_i,
  output logic step_clk_o,
  output logic step_fall_o,
  output logic strobe_o
);
  logic sclk_q, sclk_d;

  always_comb begin
    sclk_d = sclk_q;
    if (fall_i) sclk_d = ~sclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_d;
  end

  assign step_clk_o  = sclk_q;
  assign step_fall_o = fall_i & sclk_q;
  assign strobe_o    = base_i & sclk_q;
endmodule

// File: rtl/bist_step_counter.sv
module bist_step_counter
  import bist_seq_pkg::*;
#(
  parameter step_t JUMP_STEP = JUMP_STEP_DEF
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv_i,
  input  logic  jump_i,
  output step_t count_o
);
  step_t cnt_q, cnt_d;
  logic  cnt_en;

  always_comb begin
    cnt_en = adv_i;
    // load has priority over increment; wrap is natural 4-bit rollover
    cnt_d  = jump_i ? JUMP_STEP : cnt_q + step_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/bist_step_decoder.sv
module bist_step_decoder
  import bist_seq_pkg::*;
(
  input  step_t             count_i,
  input  logic              inh_a_i,
  input  logic              inh_b_i,
  output logic [STEP_N-1:0] sel_n_o
);
  logic dec_en;
  assign dec_en = ~(inh_a_i | inh_b_i);

  for (genvar i = 0; i < STEP_N; i++) begin : g_sel
    assign sel_n_o[i] = ~(dec_en & (count_i == STEP_W'(i)));
  end
endmodule

// File: rtl/bist_step_sequencer.sv
module bist_step_sequencer
  import bist_seq_pkg::*;
#(
  parameter int    PERIOD_CYC = 1_000_000,
  parameter int    PULSE_CYC  = 50_000,
  parameter step_t JUMP_STEP  = JUMP_STEP_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              jump_req,
  input  logic              dec_inh_a,
  input  logic              dec_inh_b,
  output logic [STEP_N-1:0] step_sel_n,
  output logic              strobe,
  output logic              step_clk,
  output logic [STEP_W-1:0] step_count
);
  logic  rst_sync_n;
  logic  base_pulse, base_fall, step_fall;
  step_t count;

  bist_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bist_pulse_gen #(.PERIOD_CYC(PERIOD_CYC), .PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .base_o (base_pulse),
    .fall_o (base_fall)
  );

  bist_step_clk u_sclk (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .base_i      (base_pulse),
    .fall_i      (base_fall),
    .step_clk_o  (step_clk),
    .step_fall_o (step_fall),
    .strobe_o    (strobe)
  );

  bist_step_counter #(.JUMP_STEP(JUMP_STEP)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .adv_i   (step_fall),
    .jump_i  (jump_req),
    .count_o (count)
  );

  bist_step_decoder u_dec (
    .count_i (count),
    .inh_a_i (dec_inh_a),
    .inh_b_i (dec_inh_b),
    .sel_n_o (step_sel_n)
  );

  assign step_count = count;
endmodule

// File: rtl/bist_step_sequencer_chk.sv
module bist_step_sequencer_chk
  import bist_seq_pkg::*;
#(
  parameter step_t JUMP_STEP = JUMP_STEP_DEF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              jump_req,
  input logic              dec_inh_a,
  input logic              dec_inh_b,
  input logic [STEP_N-1:0] step_sel_n,
  input logic              strobe,
  input logic              step_clk,
  input logic [STEP_W-1:0] step_count
);
  AST_FALL_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(step_clk) |-> $past(strobe)); // R4

  AST_COUNT_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (step_count != $past(step_count)) |-> $fell(step_clk)); // R5

  AST_STEP_INCREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(step_clk) && !$past(jump_req)) |-> (step_count == STEP_W'($past(step_count) + 1'b1))); // R6

  AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(step_clk) && $past(jump_req)) |-> (step_count == JUMP_STEP)); // R7

  AST_SEL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_inh_a && !dec_inh_b) |-> (!step_sel_n[step_count] && $countones(~step_sel_n) == 1)); // R8

  AST_INHIBIT_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_inh_a || dec_inh_b) |-> (&step_sel_n)); // R9
endmodule

bind bist_step_sequencer bist_step_sequencer_chk #(.JUMP_STEP(JUMP_STEP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .jump_req   (jump_req),
  .dec_inh_a  (dec_inh_a),
  .dec_inh_b  (dec_inh_b),
  .step_sel_n (step_sel_n),
  .strobe     (strobe),
  .step_clk   (step_clk),
  .step_count (step_count)
);

// File: tb/bist_step_sequencer_bench.sv
`timescale 1ns/1ps
module bist_step_sequencer_bench;
  localparam int P = 10;
  localparam int W = 3;
  localparam int NCYC = 2200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        jump_req = 1'b0;
  logic        dec_inh_a = 1'b0;
  logic        dec_inh_b = 1'b0;
  logic [15:0] step_sel_n;
  logic        strobe, step_clk;
  logic [3:0]  step_count;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // behavioural reference state
  int s1 = 0, s2 = 0, k = 0;
  int m_cnt = 0;

  always #2 clk = ~clk;

  bist_step_sequencer #(.PERIOD_CYC(P), .PULSE_CYC(W), .JUMP_STEP(4'd6)) u_bist_step_sequencer (
    .clk(clk), .rst_n(rst_n), .jump_req(jump_req),
    .dec_inh_a(dec_inh_a), .dec_inh_b(dec_inh_b),
    .step_sel_n(step_sel_n), .strobe(strobe),
    .step_clk(step_clk), .step_count(step_count)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      s1 = 0; s2 = 0; k = 0; m_cnt = 0;
    end else begin
      if (s2 == 1) begin
        k++;
        if (k >= W + 1 && ((k - W - 1) % P) == 0) begin
          if ((((k - W - 1) / P) + 1) % 2 == 0)
            m_cnt = jump_req ? 6 : (m_cnt + 1) % 16;
        end
      end
      s2 = s1;
      s1 = 1;
    end
  end

  task automatic cmp(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  task automatic check_all();
    int f;
    bit base, sclk;
    logic [15:0] sel;
    base = (k >= 1) && (((k - 1) % P) < W);
    f    = (k >= W + 1) ? ((k - W - 1) / P + 1) : 0;
    sclk = (f % 2) == 1;
    sel  = (dec_inh_a || dec_inh_b) ? 16'hFFFF : ~(16'h1 << m_cnt);
    if (!rst_n) begin
      cmp("R1 reset count", int'(step_count), 0);
      cmp("R1 reset step_clk", int'(step_clk), 0);
      cmp("R1 reset strobe", int'(strobe), 0);
      cmp("R1 reset step_sel_n", int'(step_sel_n), int'(sel));
    end else begin
      cmp("R5 R6 R7 step_count", int'(step_count), m_cnt);
      cmp("R2 R3 step_clk", int'(step_clk), int'(sclk));
      cmp("R4 strobe", int'(strobe), int'(base && sclk));
      cmp("R8 R9 step_sel_n", int'(step_sel_n), int'(sel));
    end
  endtask

  initial begin
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      @(negedge clk);
      check_all();
      rst_n     <= !(cyc < 4 || (cyc >= 1500 && cyc < 1503));
      jump_req  <= (cyc >= 700 && cyc < 760) ||
                   (cyc >= 300 && cyc < 650 && (cyc % 23) == 0) ||
                   (cyc >= 1600 && cyc < 1900 && (cyc % 20) == 5);
      dec_inh_a <= (cyc >= 200 && cyc < 260) || (cyc >= 1700 && cyc < 1703);
      dec_inh_b <= (cyc >= 1000 && cyc < 1040) || ((cyc % 50) == 7);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule